// File: doc/BRIEF.md
# Set/Clear Command Status Register

This block is the 16-bit-side control and status register of a shared-memory link port. It holds five flags: an interrupt request toward the 16-bit side, an interrupt request toward the 36-bit side, and three error flags (non-existent memory, parity error, word-count overflow). Software never has to read, modify and write the register. Each flag has its own set command bit and its own clear command bit in the written word, so one write can change any mix of flags and leave the others as they are.

The same write also loads two interrupt enables and a 3-bit interrupt assignment field. The read-back word uses a different layout. It packs the five flags, a port-enabled bit taken from an input pin, the two enables and the assignment field. Hardware error inputs set their flags directly. The block drives a 16-bit-side interrupt output and a strobe toward the 36-bit side. Address decoding is reduced to a single write-select input.

Top module: `setclr_csr`

## Requirements
- R1: After reset all five flags, both enables and the assignment field are 0, so the read word is 0 apart from bit 10, which follows `portEnable`.
- R2: A write with a flag's set bit at 1 and its clear bit at 0 sets that flag from the next cycle. The set/clear bit pairs are: 16-bit-side interrupt 15/14, 36-bit-side interrupt 13/12, non-existent memory 11/10, parity error 9/8, word-count overflow 7/6.
- R3: When a write has both the set bit and the clear bit of the same flag at 1, the flag is 0 afterwards.
- R4: A flag whose set and clear bits are both 0 in a write keeps its value, and so does every flag when `wrSel` is low.
- R5: Every write loads the error interrupt enable from write bit 5, the 16-bit-side interrupt enable from write bit 4, and the assignment field from write bits 2..0. Without a write these keep their values.
- R6: The read word `rdData` is, from bit 15 down: 16-bit-side interrupt, 36-bit-side interrupt, non-existent memory, parity error, word-count overflow, port enabled, error interrupt enable, 16-bit-side interrupt enable. Bits 7..3 are zero and bits 2..0 hold the assignment field.
- R7: A 1 on a `hwErrSet` input sets its error flag on the next edge, and this wins over a clear written in the same cycle. Bit 2 is non-existent memory, bit 1 is parity error and bit 0 is word-count overflow.
- R8: `irqHost` is 1 exactly when (the 16-bit-side interrupt flag AND its enable) OR (any error flag AND the error interrupt enable).
- R9: `irqRemote` equals the 36-bit-side interrupt flag.
- R10: Read bit 10 follows the `portEnable` input at all times, and no write changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrSel | input | 1 | Register write select |
| wrData | input | 16 | Write command word |
| hwErrSet | input | 3 | Hardware error set pulses (nxm, parity, overflow) |
| portEnable | input | 1 | Port-enabled status from outside |
| rdData | output | 16 | Status read word |
| irqHost | output | 1 | Interrupt toward the 16-bit side |
| irqRemote | output | 1 | Interrupt strobe toward the 36-bit side |

## Verification
The assertions check on every cycle how each flag reacts to its decoded set, clear and hardware strobes: clear winning over set, hardware set winning over clear, and holding when idle. They also check that the interrupt outputs agree with the read word and that the port-enabled bit follows its pin. Only the bench's scenarios can show that the bit positions of the written word map to the correct flags. The same holds for the enables and the assignment field loading from the correct bits, and for the full read layout matching an independent model over long random write sequences.

// File: rtl/csrPkg.sv
package csrPkg;
  localparam int DATA_W   = 16;
  localparam int FLAG_N   = 5;
  localparam int ERR_N    = 3;
  localparam int ASSIGN_W = 3;
  localparam int FL_HOST   = FLAG_N - 1;
  localparam int FL_REMOTE = FLAG_N - 2;
  localparam int SET_BASE  = DATA_W - 2 * FLAG_N + 1;
  localparam int ERR_EN_BIT  = SET_BASE - 2;
  localparam int HOST_EN_BIT = SET_BASE - 3;
  localparam int PAD_W = DATA_W - FLAG_N - 3 - ASSIGN_W;

  typedef struct packed {
    logic [FLAG_N-1:0]   setVec;
    logic [FLAG_N-1:0]   clrVec;
    logic                load;
    logic                errEnNew;
    logic                hostEnNew;
    logic [ASSIGN_W-1:0] assignNew;
  } strobe_t;
endpackage

// File: rtl/csrCtrl.sv
module csrCtrl
  import csrPkg::*;
(
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           cmd
);
  // Each flag i owns the pair (SET_BASE+2i, SET_BASE+2i-1).
  for (genvar i = 0; i < FLAG_N; i++) begin : g_pair
    assign cmd.setVec[i] = wrSel & wrData[SET_BASE + 2*i];
    assign cmd.clrVec[i] = wrSel & wrData[SET_BASE + 2*i - 1];
  end

  assign cmd.load      = wrSel;
  assign cmd.errEnNew  = wrData[ERR_EN_BIT];
  assign cmd.hostEnNew = wrData[HOST_EN_BIT];
  assign cmd.assignNew = wrData[ASSIGN_W-1:0];
endmodule

// File: rtl/csrDatapath.sv
module csrDatapath
  import csrPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           cmd,
  input  logic [ERR_N-1:0]  hwErrSet,
  input  logic              portEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              irqHost,
  output logic              irqRemote
);
  logic [FLAG_N-1:0]   flags;
  logic [FLAG_N-1:0]   hwVec;
  logic [FLAG_N-1:0]   flagsNext;
  logic                errEn;
  logic                hostEn;
  logic [ASSIGN_W-1:0] assignF;

  assign hwVec     = {{(FLAG_N-ERR_N){1'b0}}, hwErrSet};
  assign flagsNext = hwVec | ((flags | cmd.setVec) & ~cmd.clrVec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      errEn   <= 1'b0;
      hostEn  <= 1'b0;
      assignF <= '0;
    end else begin
      flags <= flagsNext;
      if (cmd.load) begin
        errEn   <= cmd.errEnNew;
        hostEn  <= cmd.hostEnNew;
        assignF <= cmd.assignNew;
      end
    end
  end

  assign rdData    = {flags, portEnable, errEn, hostEn, {PAD_W{1'b0}}, assignF};
  assign irqHost   = (flags[FL_HOST] & hostEn) | ((|flags[ERR_N-1:0]) & errEn);
  assign irqRemote = flags[FL_REMOTE];

  for (genvar i = 0; i < FLAG_N; i++) begin : g_chk
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.setVec[i] && !cmd.clrVec[i] |=> flags[i]);
    p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.clrVec[i] && !hwVec[i] |=> !flags[i]);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd.setVec[i] && !cmd.clrVec[i] && !hwVec[i] |=> $stable(flags[i]));
    p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hwVec[i] |=> flags[i]);
  end

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.load |=> $stable({errEn, hostEn, assignF}));
endmodule

// File: rtl/setclr_csr.sv
module setclr_csr
  import csrPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrSel,
  input  logic [15:0]       wrData,
  input  logic [2:0]        hwErrSet,
  input  logic              portEnable,
  output logic [15:0]       rdData,
  output logic              irqHost,
  output logic              irqRemote
);
  strobe_t cmd;

  csrCtrl uCtrl (
    .wrSel  (wrSel),
    .wrData (wrData),
    .cmd    (cmd)
  );

  csrDatapath uDp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .hwErrSet   (hwErrSet),
    .portEnable (portEnable),
    .rdData     (rdData),
    .irqHost    (irqHost),
    .irqRemote  (irqRemote)
  );

  p_irq_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqHost == ((rdData[15] & rdData[8]) | ((|rdData[13:11]) & rdData[9])));
  p_irq_remote_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqRemote == rdData[14]);
  p_port_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdData[10] == portEnable);
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdData[7:3] == 5'd0);
endmodule

// File: tb/setclr_csr_test.sv
`timescale 1ns/1ps
module setclr_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [2:0]  hwErrSet = '0;
  logic        portEnable = 1'b0;
  logic [15:0] rdData;
  logic        irqHost;
  logic        irqRemote;

  int  vecs = 0;
  int  errs = 0;
  bit  done = 1'b0;

  logic [4:0] mFlags = '0;  // [4]=host [3]=remote [2]=nxm [1]=par [0]=wco
  logic       mErrEn = 1'b0;
  logic       mHostEn = 1'b0;
  logic [2:0] mAssign = '0;

  always #2.5 clk = ~clk;

  setclr_csr uut (
    .clk(clk), .rst_n(rst_n), .wrSel(wrSel), .wrData(wrData),
    .hwErrSet(hwErrSet), .portEnable(portEnable),
    .rdData(rdData), .irqHost(irqHost), .irqRemote(irqRemote)
  );

  function automatic logic [15:0] expRead();
    return {mFlags, portEnable, mErrEn, mHostEn, 5'b0, mAssign};
  endfunction

  function automatic logic expIrq();
    return (mFlags[4] & mHostEn) | ((|mFlags[2:0]) & mErrEn);
  endfunction

  task automatic modelStep(input logic w, input logic [15:0] d, input logic [2:0] hw);
    for (int i = 0; i < 5; i++) begin
      logic s, c, h;
      s = w & d[7 + 2*i];
      c = w & d[6 + 2*i];
      h = (i < 3) ? hw[i] : 1'b0;
      mFlags[i] = h | ((mFlags[i] | s) & ~c);
    end
    if (w) begin
      mErrEn  = d[5];
      mHostEn = d[4];
      mAssign = d[2:0];
    end
  endtask

  task automatic checkAll(input string tag);
    vecs++;
    if (rdData !== expRead()) begin
      errs++;
      $display("FAIL %s rdData: actual %h expected %h", tag, rdData, expRead());
    end
    vecs++;
    if (irqHost !== expIrq()) begin
      errs++;
      $display("FAIL R8 (%s) irqHost: actual %b expected %b", tag, irqHost, expIrq());
    end
    vecs++;
    if (irqRemote !== mFlags[3]) begin
      errs++;
      $display("FAIL R9 (%s) irqRemote: actual %b expected %b", tag, irqRemote, mFlags[3]);
    end
  endtask

  // Drive at negedge, clock in at posedge, check at the following negedge.
  task automatic applyVec(input logic w, input logic [15:0] d, input logic [2:0] hw,
                          input logic pe, input string tag);
    wrSel = w; wrData = d; hwErrSet = hw; portEnable = pe;
    @(posedge clk);
    modelStep(w, d, hw);
    @(negedge clk);
    wrSel = 1'b0; wrData = '0; hwErrSet = '0;
    #0.5;
    checkAll(tag);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    applyVec(1'b1, 16'h8000, 3'b000, 1'b0, "R2 set host irq");
    applyVec(1'b1, 16'h2000, 3'b000, 1'b0, "R2 set remote, R4 host kept");
    applyVec(1'b1, 16'h0A80, 3'b000, 1'b0, "R2 set nxm par wco");
    applyVec(1'b1, 16'h0C00, 3'b000, 1'b0, "R3 nxm set+clear");
    applyVec(1'b0, 16'hFFFF, 3'b000, 1'b0, "R4 no write select");
    applyVec(1'b1, 16'h0035, 3'b000, 1'b0, "R5 enables and assign");
    applyVec(1'b1, 16'h4010, 3'b000, 1'b0, "R8 host cleared, R5 errEn off");
    applyVec(1'b1, 16'h0302, 3'b010, 1'b0, "R7 hw parity wins over clear");
    applyVec(1'b1, 16'h0027, 3'b000, 1'b0, "R8 error irq enabled");
    applyVec(1'b0, 16'h0000, 3'b000, 1'b1, "R10 port enable high");
    applyVec(1'b1, 16'h0000, 3'b000, 1'b1, "R10 write cannot clear port bit");
    applyVec(1'b1, 16'h1000, 3'b000, 1'b0, "R9 remote cleared");
    applyVec(1'b1, 16'hFFFF, 3'b000, 1'b0, "R3 all set+clear");
    applyVec(1'b1, 16'h0540, 3'b101, 1'b1, "R7 hw nxm and wco over clear");

    for (int n = 0; n < 400; n++) begin
      logic        w;
      logic [15:0] d;
      logic [2:0]  hw;
      logic        pe;
      w  = ($urandom % 4) != 0;
      d  = 16'($urandom);
      hw = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      pe = 1'($urandom);
      applyVec(w, d, hw, pe, "R2/R3/R4/R5/R6/R7 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule